// File: doc/BRIEF.md
# Serial Peripheral Master with Per-Word Select Pulsing

This block is a synchronous serial master that uses clock-low idle and sample-on-rising-edge framing. Words are written into an 8-entry transmit queue and shifted out most significant bit first. At the same time, the block shifts in an equal-length word from the serial input and stores it in an 8-entry receive queue. The block generates the serial clock and an active-low word select. The serial clock half-period is a programmable number of system clocks.

Every word has its own select frame. When several words are queued back to back, the select line goes high for one full serial-clock period between them. The next word then starts with a fresh falling edge and the same half-period of data setup. The enable input is honoured only between words, so a frame that has begun always runs to its end.

Top module: `spi_frame_master`

## Requirements
- R1: After reset, and whenever no frame is in progress, `sclk` is 0, `sel_n` is 1, `mosi` is 0, `busy` is 0 and `rx_empty` is 1.
- R2: A frame starts, with `sel_n` falling, only when `enable` is 1 and the transmit queue holds a word. While `enable` is 0, a queued word is not sent.
- R3: The first data bit appears on `mosi` one half-period after `sel_n` falls. The first rising edge of `sclk` comes exactly two half-periods after `sel_n` falls.
- R4: Each frame has exactly WORD_W rising edges of `sclk`. `mosi` changes only on falling edges, and `miso` is sampled on rising edges. Both directions carry the most significant bit first.
- R5: `sel_n` returns high exactly two half-periods after the last rising edge of `sclk` in a frame.
- R6: When another word is queued and `enable` is 1 at the end of a frame, `sel_n` stays high for exactly two half-periods and then falls for the next word.
- R7: A half-period lasts `half_div` system clocks. A `half_div` of 0 behaves as 1.
- R8: Each queue holds 8 words. A write to a full transmit queue is dropped. `rx_rd_data` always shows the oldest received word, and `rx_rd_en` removes it.
- R9: A received word is queued once its last bit has been sampled. If the receive queue is full, the word is dropped and `rx_overrun` is set and stays set until reset.
- R10: `busy` is 1 while `sel_n` is low. During the gap between words, `busy` is 1 only if another word is queued and `enable` is 1. Otherwise `busy` is 0 once `sel_n` is high.
- R11: If `enable` is cleared during a frame, that frame completes with all WORD_W clock edges, and no further frame starts until `enable` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Permits new frames to start |
| half_div | input | DIV_W | Serial clock half-period in system clocks (0 acts as 1) |
| tx_wr_en | input | 1 | Push `tx_wr_data` into the transmit queue |
| tx_wr_data | input | WORD_W | Word to transmit |
| tx_full | output | 1 | Transmit queue full |
| rx_rd_en | input | 1 | Pop the oldest received word |
| rx_rd_data | output | WORD_W | Oldest received word |
| rx_empty | output | 1 | Receive queue empty |
| rx_overrun | output | 1 | Sticky flag: a received word was dropped |
| busy | output | 1 | Frame active or next frame pending in a gap |
| sclk | output | 1 | Serial clock, idle low |
| sel_n | output | 1 | Active-low word select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench measures the select-to-first-edge setup, the last-edge-to-release hold and the inter-word gap in system clocks, using several divider values including 0. A design that merged a burst under one select, or that was off by a half-period in setup or gap, would show a wrong interval. Back-to-back runs check that the select actually rises between words and that `busy` holds through the gap but drops after the final word. The enable test clears `enable` in mid-frame; a design that aborted the frame would lose clock edges, and one that ignored the clear would send the second word. Filling the receive queue checks that a ninth word is dropped rather than overwriting stored data, and that the overrun flag latches.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_GAP    = 2'd2
    } fm_state_e;

endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wr_ptr_d, wr_ptr_q;
    logic [AW-1:0]    rd_ptr_d, rd_ptr_q;
    logic [CW-1:0]    cnt_d, cnt_q;
    logic             do_wr, do_rd;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign rd_data = mem_q[rd_ptr_q];

    always_comb begin
        do_wr    = wr_en && !full;
        do_rd    = rd_en && !empty;
        wr_ptr_d = wr_ptr_q;
        rd_ptr_d = rd_ptr_q;
        cnt_d    = cnt_q;
        if (do_wr) begin
            wr_ptr_d = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
        end
        if (do_rd) begin
            rd_ptr_d = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
        end
        case ({do_wr, do_rd})
            2'b10:   cnt_d = cnt_q + 1'b1;
            2'b01:   cnt_d = cnt_q - 1'b1;
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            wr_ptr_q <= wr_ptr_d;
            rd_ptr_q <= rd_ptr_d;
            cnt_q    <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem_q[wr_ptr_q] <= wr_data;
        end
    end

endmodule

// File: rtl/spi_fm_half_timer.sv
module spi_fm_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] last;

    always_comb begin
        last  = (half_div == '0) ? '0 : half_div - 1'b1;
        tick  = !clear && (cnt_q >= last);
        cnt_d = (clear || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
    import spi_fm_pkg::*;
#(
    parameter int WORD_W     = 8,
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              tx_wr_en,
    input  logic [WORD_W-1:0] tx_wr_data,
    output logic              tx_full,
    input  logic              rx_rd_en,
    output logic [WORD_W-1:0] rx_rd_data,
    output logic              rx_empty,
    output logic              rx_overrun,
    output logic              busy,
    output logic              sclk,
    output logic              sel_n,
    output logic              mosi,
    input  logic              miso
);
    localparam int PH_LAST = 2 * WORD_W + 2;
    localparam int PH_W    = $clog2(PH_LAST + 1);

    typedef struct packed {
        fm_state_e         st;
        logic [PH_W-1:0]   ph;
        logic              sclk;
        logic              sel_n;
        logic              mosi;
        logic [WORD_W-1:0] tx_sh;
        logic [WORD_W-1:0] rx_sh;
        logic              ovr;
    } regs_t;

    regs_t r_d, r_q;

    logic              tick;
    logic              tmr_clr;
    logic              tx_pop;
    logic              tx_empty;
    logic [WORD_W-1:0] tx_head;
    logic              rx_push;
    logic              rx_full;
    logic [WORD_W-1:0] rx_word;
    logic [PH_W-1:0]   ph_n;

    spi_fm_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tx_wr_en),
        .wr_data (tx_wr_data),
        .rd_en   (tx_pop),
        .rd_data (tx_head),
        .full    (tx_full),
        .empty   (tx_empty)
    );

    spi_fm_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rx_push),
        .wr_data (rx_word),
        .rd_en   (rx_rd_en),
        .rd_data (rx_rd_data),
        .full    (rx_full),
        .empty   (rx_empty)
    );

    spi_fm_half_timer #(.DIV_W(DIV_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (tmr_clr),
        .half_div (half_div),
        .tick     (tick)
    );

    always_comb begin
        r_d     = r_q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        rx_word = {r_q.rx_sh[WORD_W-2:0], miso};
        tmr_clr = (r_q.st == ST_IDLE);
        ph_n    = r_q.ph + 1'b1;

        case (r_q.st)
            ST_IDLE: begin
                r_d.sclk  = 1'b0;
                r_d.sel_n = 1'b1;
                r_d.mosi  = 1'b0;
                if (enable && !tx_empty) begin
                    tx_pop    = 1'b1;
                    r_d.tx_sh = tx_head;
                    r_d.sel_n = 1'b0;
                    r_d.ph    = '0;
                    r_d.st    = ST_ACTIVE;
                end
            end

            ST_ACTIVE: begin
                if (tick) begin
                    r_d.ph = ph_n;
                    if (ph_n == PH_W'(1)) begin
                        r_d.mosi = r_q.tx_sh[WORD_W-1];
                    end else if (ph_n == PH_W'(PH_LAST)) begin
                        r_d.sel_n = 1'b1;
                        r_d.ph    = '0;
                        r_d.st    = ST_GAP;
                    end else if (ph_n == PH_W'(PH_LAST - 1)) begin
                        r_d.sclk = 1'b0;
                        r_d.mosi = 1'b0;
                    end else if (!ph_n[0]) begin
                        r_d.sclk  = 1'b1;
                        r_d.rx_sh = rx_word;
                        if (ph_n == PH_W'(2 * WORD_W)) begin
                            rx_push = 1'b1;
                        end
                    end else begin
                        r_d.sclk  = 1'b0;
                        r_d.tx_sh = r_q.tx_sh << 1;
                        r_d.mosi  = r_q.tx_sh[WORD_W-2];
                    end
                end
            end

            ST_GAP: begin
                if (tick) begin
                    r_d.ph = ph_n;
                    if (r_q.ph[0]) begin
                        r_d.ph = '0;
                        if (enable && !tx_empty) begin
                            tx_pop    = 1'b1;
                            r_d.tx_sh = tx_head;
                            r_d.sel_n = 1'b0;
                            r_d.st    = ST_ACTIVE;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
            end

            default: r_d.st = ST_IDLE;
        endcase

        if (rx_push && rx_full) begin
            r_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.sel_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sclk       = r_q.sclk;
    assign sel_n      = r_q.sel_n;
    assign mosi       = r_q.mosi;
    assign rx_overrun = r_q.ovr;
    assign busy       = (r_q.st == ST_ACTIVE) ||
                        ((r_q.st == ST_GAP) && enable && !tx_empty);

endmodule

// File: rtl/spi_frame_master_chk.sv
module spi_frame_master_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic sclk,
    input logic sel_n,
    input logic mosi,
    input logic busy,
    input logic rx_overrun,
    input logic tx_empty,
    input logic tx_pop,
    input logic rx_push,
    input logic rx_full
);

    p_idle_levels_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> (!sclk && !mosi));

    p_start_needs_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_n) |-> $past(enable && !tx_empty));

    p_start_pops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_n) |-> $past(tx_pop));

    p_rise_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> (!sel_n && $stable(mosi)));

    p_overrun_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> rx_overrun);

    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |=> rx_overrun);

    p_busy_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_n |-> busy);

endmodule

bind spi_frame_master spi_frame_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .sclk       (sclk),
    .sel_n      (sel_n),
    .mosi       (mosi),
    .busy       (busy),
    .rx_overrun (rx_overrun),
    .tx_empty   (tx_empty),
    .tx_pop     (tx_pop),
    .rx_push    (rx_push),
    .rx_full    (rx_full)
);

// File: tb/test_spi_frame_master.sv
`timescale 1ns/1ps
module test_spi_frame_master;
    localparam int W = 8;
    localparam int NV = 6;
    // {tx word, slave word, half_div}
    localparam logic [23:0] VEC [NV] = '{
        24'hA5_3C_02, 24'h01_80_01, 24'hFF_00_03,
        24'h00_FF_00, 24'h96_69_04, 24'h7E_C3_02
    };

    logic clk = 0, rst_n = 0, enable = 0;
    logic [7:0] half_div = 8'd2;
    logic tx_wr_en = 0, rx_rd_en = 0, miso = 0;
    logic [W-1:0] tx_wr_data = '0;
    logic tx_full, rx_empty, rx_overrun, busy, sclk, sel_n, mosi;
    logic [W-1:0] rx_rd_data;

    spi_frame_master i_spi_frame_master (
        .clk(clk), .rst_n(rst_n), .enable(enable), .half_div(half_div),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data), .tx_full(tx_full),
        .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data), .rx_empty(rx_empty),
        .rx_overrun(rx_overrun), .busy(busy), .sclk(sclk), .sel_n(sel_n),
        .mosi(mosi), .miso(miso)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0, frames = 0, rises = 0;
    int t_fall = 0, t_first = 0, t_last = 0, t_rise = 0, gap = 0;
    logic [W-1:0] sent = '0, sl_sh = '0;
    logic [W-1:0] slv [64];
    bit done = 0;

    always @(negedge clk) cyc = cyc + 1;

    always @(negedge sel_n) begin
        gap     = cyc - t_rise;
        t_fall  = cyc;
        rises   = 0;
        sl_sh   = slv[frames % 64];
        miso    = sl_sh[W-1];
    end
    always @(posedge sclk) begin
        if (rises == 0) t_first = cyc;
        t_last = cyc;
        rises  = rises + 1;
        sent   = {sent[W-2:0], mosi};
    end
    always @(negedge sclk) begin
        sl_sh = sl_sh << 1;
        miso  = sl_sh[W-1];
    end
    always @(posedge sel_n) begin
        t_rise = cyc;
        frames = frames + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_tx(input logic [W-1:0] d);
        @(negedge clk); tx_wr_en = 1; tx_wr_data = d;
        @(negedge clk); tx_wr_en = 0;
    endtask

    task automatic pop_rx(input logic [W-1:0] exp, input string req);
        @(negedge clk);
        chk(!rx_empty, req, rx_empty, 0);
        chk(rx_rd_data == exp, req, rx_rd_data, exp);
        rx_rd_en = 1;
        @(negedge clk); rx_rd_en = 0;
    endtask

    task automatic wait_idle();
        int k = 0;
        @(negedge clk);
        while ((busy || !sel_n) && k < 5000) begin @(negedge clk); k++; end
        repeat (40) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int f0, h;
        for (int i = 0; i < 64; i++) slv[i] = 8'(i * 37 + 5);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset levels
        chk(!sclk && sel_n && !mosi && !busy && rx_empty, "R1",
            {sclk, sel_n, mosi, busy, rx_empty}, 5'b01001);

        // Table: single words at several dividers (R3 R4 R5 R7 R8)
        enable = 1;
        for (int v = 0; v < NV; v++) begin
            half_div = VEC[v][7:0];
            h = (VEC[v][7:0] == 0) ? 1 : int'(VEC[v][7:0]);
            slv[frames % 64] = VEC[v][15:8];
            f0 = frames;
            push_tx(VEC[v][23:16]);
            wait_idle();
            chk(frames == f0 + 1, "R2", frames - f0, 1);
            chk(rises == W, "R4", rises, W);
            chk(sent == VEC[v][23:16], "R4", sent, VEC[v][23:16]);
            chk(t_first - t_fall == 2 * h, "R3 R7", t_first - t_fall, 2 * h);
            chk(t_rise - t_last == 2 * h, "R5", t_rise - t_last, 2 * h);
            chk(!sclk && sel_n && !mosi && !busy, "R1", {sclk, sel_n, mosi, busy}, 4'b0100);
            pop_rx(VEC[v][15:8], "R8");
        end

        // R2: disabled, queued word not sent
        enable = 0; half_div = 8'd3;
        f0 = frames;
        push_tx(8'h3A); push_tx(8'hC5); push_tx(8'h5F);
        repeat (100) @(negedge clk);
        chk(frames == f0 && sel_n, "R2", frames - f0, 0);

        // R6 R10: back-to-back burst with select gaps
        enable = 1;
        @(posedge sel_n); @(negedge clk);
        chk(busy && sel_n, "R10", busy, 1);
        @(negedge sel_n); @(negedge clk);
        chk(gap == 6, "R6", gap, 6);
        @(posedge sel_n);
        @(negedge sel_n); @(negedge clk);
        chk(gap == 6, "R6", gap, 6);
        @(posedge sel_n); @(negedge clk);
        chk(!busy, "R10", busy, 0);
        chk(sent == 8'h5F, "R4", sent, 8'h5F);
        wait_idle();
        chk(frames == f0 + 3, "R6", frames - f0, 3);
        for (int k = 0; k < 3; k++) pop_rx(slv[(f0 + k) % 64], "R4");

        // R11: enable cleared mid-frame
        half_div = 8'd2; enable = 0;
        f0 = frames;
        push_tx(8'hE1); push_tx(8'h1E);
        enable = 1;
        @(negedge sel_n); @(negedge clk); enable = 0;
        repeat (300) @(negedge clk);
        chk(frames == f0 + 1, "R11", frames - f0, 1);
        chk(rises == W && sent == 8'hE1, "R11", rises, W);
        chk(sel_n && !busy, "R11", sel_n, 1);
        enable = 1;
        wait_idle();
        chk(frames == f0 + 2 && sent == 8'h1E, "R11", sent, 8'h1E);
        pop_rx(slv[f0 % 64], "R11");
        pop_rx(slv[(f0 + 1) % 64], "R11");

        // R8 R9: full transmit queue, then receive overrun
        enable = 0;
        f0 = frames;
        for (int k = 0; k < 9; k++) push_tx(8'(k + 8'h40));
        chk(tx_full, "R8", tx_full, 1);
        enable = 1;
        wait_idle();
        chk(frames == f0 + 8, "R8", frames - f0, 8);
        chk(!rx_overrun, "R9", rx_overrun, 0);
        push_tx(8'h99);
        wait_idle();
        chk(rx_overrun, "R9", rx_overrun, 1);
        for (int k = 0; k < 8; k++) pop_rx(slv[(f0 + k) % 64], "R9");
        @(negedge clk);
        chk(rx_empty, "R9", rx_empty, 1);
        chk(rx_overrun, "R9", rx_overrun, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule